// File: doc/BRIEF.md
# VLAN Violation Capture Unit

This block sits beside a VLAN membership table. It watches the result of every ingress lookup and records the first frame that breaks VLAN policy. A frame breaks policy in one of two ways. In the first, its VID has no table entry (a miss). In the second, the entry exists but the ingress port is not a member of that VLAN (a member violation). The block keeps the ingress port, the VID and the kind of violation, and it holds a level interrupt to the host.

The host services the interrupt by writing the get-and-clear op code into the command register shared with the table operations. The command register shows busy for a fixed number of cycles. When busy falls, the result fields hold the port number, the two violation flags, an overflow flag and the VID, and the pending state is gone. Only one violation is held at a time. Any violation that arrives while one is pending is dropped and noted in a sticky overflow bit, which the next get-and-clear reports and then clears.

Top module: `vlan_viol_capture`

## Requirements
- R1: After reset, irq_o, busy_o and every result output are 0.
- R2: A lookup strobe with hit_i=0 is a miss violation. A strobe with hit_i=1 and member_i=0 is a member violation. A strobe with hit_i=1 and member_i=1 is no violation. At most one of res_miss_o and res_member_o is ever 1.
- R3: irq_o rises in the cycle after a violation is captured. It stays high until a get-and-clear completes and falls in the cycle after completion.
- R4: A cmd_wr_i pulse with cmd_op_i equal to OP_GET_CLR (3'b110 by default) while busy_o=0 starts a get-and-clear. busy_o is then 1 for exactly OP_LAT cycles, and the results are valid in the first cycle with busy_o=0.
- R5: The results of a get-and-clear are the port, VID and violation flag of the captured violation.
- R6: While a violation is pending, later violations are dropped and the first one is kept. A drop sets res_ovf_o in the next result, and that get-and-clear clears the overflow state.
- R7: A get-and-clear with no violation pending returns port 0, VID 0 and both flags 0, and irq_o stays 0.
- R8: A command write while busy_o=1 is ignored, and so is a write with any other op code. busy_o, irq_o and the results do not change.
- R9: A violation whose strobe falls on the completion cycle of a get-and-clear is captured as the new pending violation. The completing results still describe the old one.
- R10: The result outputs change only on the completion of a get-and-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | One-cycle strobe: lookup result valid |
| lkp_port_i | input | PORT_W | Ingress port of the frame |
| lkp_vid_i | input | VID_W | VID of the frame |
| lkp_hit_i | input | 1 | Table has an entry for the VID |
| lkp_member_i | input | 1 | Ingress port is a member of the VLAN |
| cmd_wr_i | input | 1 | Command register write strobe |
| cmd_op_i | input | OP_W | Command op code |
| busy_o | output | 1 | Command in progress |
| irq_o | output | 1 | Violation pending (level) |
| res_port_o | output | PORT_W | Reported ingress port |
| res_member_o | output | 1 | Reported member violation flag |
| res_miss_o | output | 1 | Reported miss violation flag |
| res_ovf_o | output | 1 | Reported drop flag |
| res_vid_o | output | VID_W | Reported VID |

## Verification
If the pending flag is stuck or cleared at the wrong time, irq_o shows it one cycle after a strobe or after a completion. It also shows as an empty report where a full one is expected, or the reverse. If the capture registers are wrong, or are overwritten by a later violation, the next report returns the wrong port, VID or flag. The overflow state can only be seen at the first completion after a drop. A miscounted latency shows as busy_o falling one cycle early or late, and the results appear on that same edge.

// File: rtl/vvc_pkg.sv
package vvc_pkg;
  localparam int unsigned OP_W       = 3;
  localparam logic [2:0]  OP_GET_CLR = 3'b110;

  typedef struct packed {
    logic miss;
    logic member;
  } viol_flags_t;
endpackage

// File: rtl/vvc_classify.sv
module vvc_classify
  import vvc_pkg::*;
(
  input  logic        valid_i,
  input  logic        hit_i,
  input  logic        member_i,
  output logic        viol_o,
  output viol_flags_t flags_o
);
  always_comb begin
    flags_o.miss   = valid_i && !hit_i;
    flags_o.member = valid_i && hit_i && !member_i;
    viol_o         = flags_o.miss || flags_o.member;
  end
endmodule

// File: rtl/vvc_cmd_seq.sv
module vvc_cmd_seq #(
  parameter int unsigned OP_W   = 3,
  parameter int unsigned OP_LAT = 2,
  parameter logic [OP_W-1:0] GET_CLR = '1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [OP_W-1:0] op_i,
  output logic            busy_o,
  output logic            done_o
);
  localparam int unsigned CNT_W = (OP_LAT > 1) ? $clog2(OP_LAT) : 1;

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start;

  assign start  = wr_i && (op_i == GET_CLR) && !busy_q;
  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(OP_LAT - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  p_start_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && op_i == GET_CLR && !busy_o) |=> busy_o);
  p_busy_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  p_done_ends_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/vvc_capture.sv
module vvc_capture
  import vvc_pkg::*;
#(
  parameter int unsigned PORT_W  = 3,
  parameter int unsigned VID_W   = 12,
  parameter bit          HAS_OVF = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              viol_i,
  input  viol_flags_t       flags_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [VID_W-1:0]  vid_i,
  input  logic              done_i,
  output logic              pend_o,
  output logic              ovf_o,
  output viol_flags_t       flags_o,
  output logic [PORT_W-1:0] port_o,
  output logic [VID_W-1:0]  vid_o
);
  logic pend_q;
  logic take;
  logic drop;

  // a completion frees the slot in the same edge
  assign take = viol_i && (!pend_q || done_i);
  assign drop = viol_i && pend_q && !done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      flags_o <= '0;
      port_o  <= '0;
      vid_o   <= '0;
    end else begin
      if (take) begin
        pend_q  <= 1'b1;
        flags_o <= flags_i;
        port_o  <= port_i;
        vid_o   <= vid_i;
      end else if (done_i) begin
        pend_q  <= 1'b0;
      end
    end
  end

  assign pend_o = pend_q;

  if (HAS_OVF) begin : g_ovf
    logic ovf_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ovf_q <= 1'b0;
      else if (done_i) ovf_q <= 1'b0;
      else if (drop)   ovf_q <= 1'b1;
    end
    assign ovf_o = ovf_q;

    p_ovf_needs_pend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_q |-> pend_q);
  end else begin : g_no_ovf
    assign ovf_o = 1'b0;
  end

  p_first_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !done_i) |=> ($stable(port_o) && $stable(vid_o) && $stable(flags_o)));
endmodule

// File: rtl/vlan_viol_capture.sv
module vlan_viol_capture
  import vvc_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned VID_W     = 12,
  parameter int unsigned OP_LAT    = 2,
  parameter bit          HAS_OVF   = 1'b1,
  localparam int unsigned PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_valid_i,
  input  logic [PORT_W-1:0] lkp_port_i,
  input  logic [VID_W-1:0]  lkp_vid_i,
  input  logic              lkp_hit_i,
  input  logic              lkp_member_i,
  input  logic              cmd_wr_i,
  input  logic [OP_W-1:0]   cmd_op_i,
  output logic              busy_o,
  output logic              irq_o,
  output logic [PORT_W-1:0] res_port_o,
  output logic              res_member_o,
  output logic              res_miss_o,
  output logic              res_ovf_o,
  output logic [VID_W-1:0]  res_vid_o
);
  logic              viol;
  viol_flags_t       lkp_flags;
  logic              done;
  logic              pend;
  logic              ovf;
  viol_flags_t       cap_flags;
  logic [PORT_W-1:0] cap_port;
  logic [VID_W-1:0]  cap_vid;

  vvc_classify u_cls (
    .valid_i  (lkp_valid_i),
    .hit_i    (lkp_hit_i),
    .member_i (lkp_member_i),
    .viol_o   (viol),
    .flags_o  (lkp_flags)
  );

  vvc_cmd_seq #(
    .OP_W    (OP_W),
    .OP_LAT  (OP_LAT),
    .GET_CLR (OP_GET_CLR)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cmd_wr_i),
    .op_i   (cmd_op_i),
    .busy_o (busy_o),
    .done_o (done)
  );

  vvc_capture #(
    .PORT_W  (PORT_W),
    .VID_W   (VID_W),
    .HAS_OVF (HAS_OVF)
  ) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .viol_i  (viol),
    .flags_i (lkp_flags),
    .port_i  (lkp_port_i),
    .vid_i   (lkp_vid_i),
    .done_i  (done),
    .pend_o  (pend),
    .ovf_o   (ovf),
    .flags_o (cap_flags),
    .port_o  (cap_port),
    .vid_o   (cap_vid)
  );

  assign irq_o = pend;

  // result fields: loaded only when a get-and-clear completes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_port_o   <= '0;
      res_member_o <= 1'b0;
      res_miss_o   <= 1'b0;
      res_ovf_o    <= 1'b0;
      res_vid_o    <= '0;
    end else if (done) begin
      res_port_o   <= pend ? cap_port         : '0;
      res_member_o <= pend && cap_flags.member;
      res_miss_o   <= pend && cap_flags.miss;
      res_ovf_o    <= ovf;
      res_vid_o    <= pend ? cap_vid          : '0;
    end
  end

  p_irq_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && !(lkp_hit_i && lkp_member_i)) |=> irq_o);
  p_irq_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) == 1'b0 && !irq_o && !lkp_valid_i) |=> !irq_o);
  p_flags_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({res_member_o, res_miss_o}));
  p_res_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable({res_port_o, res_member_o, res_miss_o, res_ovf_o, res_vid_o}));
  p_empty_report_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !irq_o) |=> !(res_member_o || res_miss_o) || busy_o);
endmodule

// File: tb/sim_vlan_viol_capture.sv
module sim_vlan_viol_capture;
  localparam int CLK_PERIOD = 10;
  localparam int NP     = 8;
  localparam int PW     = 3;
  localparam int VW     = 12;
  localparam int LAT    = 2;
  localparam logic [2:0] GET = 3'b110;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lkp_valid = 1'b0;
  logic [PW-1:0] lkp_port = '0;
  logic [VW-1:0] lkp_vid = '0;
  logic          lkp_hit = 1'b0;
  logic          lkp_member = 1'b0;
  logic          cmd_wr = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic          busy, irq, r_mbr, r_miss, r_ovf;
  logic [PW-1:0] r_port;
  logic [VW-1:0] r_vid;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  // reference model
  logic          m_pend = 0, m_miss = 0, m_mbr = 0, m_ovf = 0;
  logic [PW-1:0] m_port = '0;
  logic [VW-1:0] m_vid = '0;
  logic          e_miss = 0, e_mbr = 0, e_ovf = 0;
  logic [PW-1:0] e_port = '0;
  logic [VW-1:0] e_vid = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlan_viol_capture #(.NUM_PORTS(NP), .VID_W(VW), .OP_LAT(LAT), .HAS_OVF(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_valid_i(lkp_valid), .lkp_port_i(lkp_port), .lkp_vid_i(lkp_vid),
    .lkp_hit_i(lkp_hit), .lkp_member_i(lkp_member),
    .cmd_wr_i(cmd_wr), .cmd_op_i(cmd_op),
    .busy_o(busy), .irq_o(irq),
    .res_port_o(r_port), .res_member_o(r_mbr), .res_miss_o(r_miss),
    .res_ovf_o(r_ovf), .res_vid_o(r_vid)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic exp_busy);
    chk(req, "busy", 32'(busy), 32'(exp_busy));
    chk(req, "irq", 32'(irq), 32'(m_pend));
    chk(req, "port", 32'(r_port), 32'(e_port));
    chk(req, "member", 32'(r_mbr), 32'(e_mbr));
    chk(req, "miss", 32'(r_miss), 32'(e_miss));
    chk(req, "ovf", 32'(r_ovf), 32'(e_ovf));
    chk(req, "vid", 32'(r_vid), 32'(e_vid));
  endtask

  function automatic void model_lookup(input logic [PW-1:0] p, input logic [VW-1:0] v,
                                       input logic h, input logic m);
    if (!h || !m) begin
      if (!m_pend) begin
        m_pend = 1; m_port = p; m_vid = v; m_miss = !h; m_mbr = h && !m;
      end else begin
        m_ovf = 1;
      end
    end
  endfunction

  function automatic void model_done();
    e_port = m_pend ? m_port : '0;
    e_vid  = m_pend ? m_vid  : '0;
    e_miss = m_pend && m_miss;
    e_mbr  = m_pend && m_mbr;
    e_ovf  = m_ovf;
    m_pend = 0; m_ovf = 0;
  endfunction

  task automatic drive_lkp(input logic [PW-1:0] p, input logic [VW-1:0] v, input logic h, input logic m);
    lkp_valid = 1; lkp_port = p; lkp_vid = v; lkp_hit = h; lkp_member = m;
  endtask

  task automatic lookup(input logic [PW-1:0] p, input logic [VW-1:0] v, input logic h, input logic m);
    @(negedge clk);
    drive_lkp(p, v, h, m);
    @(negedge clk);
    lkp_valid = 0;
    model_lookup(p, v, h, m);
  endtask

  task automatic get_clear(input string req);
    @(negedge clk);
    cmd_wr = 1; cmd_op = GET;
    @(negedge clk);
    cmd_wr = 0;
    chk(req, "busy after start", 32'(busy), 32'd1);
    repeat (LAT) @(negedge clk);
    model_done();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_all("R1", 1'b0);
    rst_n = 1;
    @(negedge clk);
    chk_all("R1", 1'b0);

    // R2 R3 R5 R7 sweep: all ports, all hit/member combinations
    for (int p = 0; p < NP; p++) begin
      for (int c = 0; c < 4; c++) begin
        logic h, m;
        logic [VW-1:0] v;
        h = c[1]; m = c[0];
        v = VW'((p * 517 + c * 1303 + 5) % 4096);
        lookup(PW'(p), v, h, m);
        chk_all((h && m) ? "R2" : "R3", 1'b0);
        get_clear((h && m) ? "R7" : "R5");
        chk_all((h && m) ? "R7" : "R5", 1'b0);
      end
    end

    // R6 overflow: first violation kept, second dropped
    lookup(3'd5, 12'hABC, 1'b0, 1'b0);
    lookup(3'd2, 12'h123, 1'b1, 1'b0);
    lookup(3'd7, 12'hFFF, 1'b1, 1'b1);
    chk_all("R6", 1'b0);
    get_clear("R6");
    chk_all("R6", 1'b0);
    chk(  "R6", "ovf reported", 32'(r_ovf), 32'd1);
    get_clear("R6");
    chk_all("R6", 1'b0);

    // R8 other op code ignored
    lookup(3'd1, 12'h055, 1'b1, 1'b0);
    @(negedge clk);
    cmd_wr = 1; cmd_op = 3'b001;
    @(negedge clk);
    cmd_wr = 0;
    chk_all("R8", 1'b0);
    repeat (3) @(negedge clk);
    // R10 results hold while idle
    chk_all("R10", 1'b0);

    // R8 write while busy ignored
    @(negedge clk);
    cmd_wr = 1; cmd_op = GET;
    @(negedge clk);
    chk("R8", "busy", 32'(busy), 32'd1);
    @(negedge clk);
    cmd_wr = 0;
    repeat (LAT - 1) @(negedge clk);
    model_done();
    chk_all("R8", 1'b0);
    @(negedge clk);
    chk_all("R8", 1'b0);

    // R9 violation on the completion edge
    lookup(3'd4, 12'h444, 1'b0, 1'b1);
    @(negedge clk);
    cmd_wr = 1; cmd_op = GET;
    @(negedge clk);
    cmd_wr = 0;
    repeat (LAT - 1) @(negedge clk);
    drive_lkp(3'd6, 12'h666, 1'b1, 1'b0);
    @(negedge clk);
    lkp_valid = 0;
    model_done();
    model_lookup(3'd6, 12'h666, 1'b1, 1'b0);
    chk_all("R9", 1'b0);
    get_clear("R9");
    chk_all("R9", 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk) cycles++;
endmodule